// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is a DMA engine for the transmit side of an Ethernet MAC. On a kick it walks a ring of 8-byte descriptors in memory, beginning at the current pointer. For every descriptor that is marked ready and has a non-zero length, it fetches the data buffer one byte at a time and streams the bytes to the MAC. Consecutive ready descriptors form one frame, which ends at the descriptor carrying the last flag. After its buffer has been sent, each processed descriptor has its status bits cleared and is written back. An event pulse follows when the descriptor asks for one.

Two settings are taken from the descriptor that opens a frame and then hold for the whole frame. The first is zero padding up to 64 bytes. The second is the offload mode, which drops an 8-byte control header at the front of the frame. The walk ends when the next descriptor address would equal the ring base. The block then reports the base as the new pointer and sets a halt bit for the ring in a 32-bit mask. Holding the pointer and halt registers is the job of the host register file. This block only reports the new values.

Top module: `tdr_walker`

## Requirements
- R1: A descriptor occupies 8 bytes at byte offsets 0..7: a 16-bit flags field (offsets 0-1), a 16-bit length (offsets 2-3), then a 32-bit buffer pointer (offsets 4-7). With `little_endian` high, each field is little-endian; with it low, each field is big-endian. Memory words carry byte offset 0 in bits 7:0.
- R2: Bits 2:0 of `ring_base` and `ring_ptr` are ignored. Every memory address carries `addr_ext` in bits 35:32, and every access is word aligned (address bits 1:0 zero).
- R3: A descriptor whose ready flag (bit 15) is clear produces no bytes and no event, and it is not written back.
- R4: The next descriptor address is the ring base when the wrap flag (bit 13) is set, and the current address plus 8 otherwise. When the next address equals the base, the walk ends with a one-cycle `walk_done`, `ptr_out` equal to the masked base, and `halt_mask` holding only bit 31 minus `ring_id`.
- R5: A ready descriptor of length zero is skipped: no bytes, no event, no writeback, and it does not open a frame.
- R6: Buffer bytes of the ready descriptors are sent in address order, one per `tx_vld` cycle. `tx_last` marks the final byte of a frame, and a frame closes at the descriptor whose last flag (bit 11) is set.
- R7: When the opening descriptor's pad flag (bit 10) or `pad_enable` is set, a frame of fewer than 64 bytes is extended with zero bytes to 64 bytes. The count includes any header bytes that are later dropped.
- R8: When the opening descriptor's offload flag (bit 14) is set, the first 8 bytes of the frame are not sent.
- R9: A processed descriptor whose interrupt flag (bit 12) is set causes one `evt_frame` pulse if it carries the last flag, and one `evt_buf` pulse otherwise. The two never pulse together.
- R10: Writeback rewrites the first descriptor word in the same byte order. The length is kept. Flag bits 15, 14, 8, 7, 6, 5:2 and 1 are cleared, and bits 13:9 and 0 are kept.
- R11: A kick while `tx_enable` is low produces no memory access, no output bytes and no `walk_done`.
- R12: The pad and offload flags of descriptors after the opening one have no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Start one walk of the ring (ignored while walking) |
| tx_enable | input | 1 | Transmit enable, sampled at kick |
| pad_enable | input | 1 | Global pad-to-64 enable, sampled at kick |
| little_endian | input | 1 | Descriptor byte order, sampled at kick |
| ring_id | input | RING_W | Ring number that selects the halt bit |
| ring_base | input | 32 | Ring base address (bits 2:0 ignored) |
| ring_ptr | input | 32 | Current descriptor pointer (bits 2:0 ignored) |
| addr_ext | input | ADDR_EXT_W | Upper address bits 35:32 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32+ADDR_EXT_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| tx_vld | output | 1 | Output byte valid |
| tx_byte | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| evt_buf | output | 1 | Buffer event pulse |
| evt_frame | output | 1 | Frame event pulse |
| walk_done | output | 1 | Walk finished pulse |
| ptr_out | output | 32 | New descriptor pointer, valid with walk_done |
| halt_mask | output | 32 | Halt bit for the ring, valid with walk_done |

## Verification
The bench builds rings that mix ready, not-ready and zero-length descriptors, uses unaligned buffers, and runs both byte orders. A design that decoded the wrong byte order would fetch from the wrong buffer. A design that wrote back skipped descriptors would change their ready bit. Frames that span several descriptors carry pad and offload flags only on a later descriptor, which catches a design that takes these decisions from the wrong descriptor. A 20-byte offload frame with padding checks that padding counts the dropped header bytes: a wrong design sends 64 bytes instead of 56. A walk that starts in the middle of the ring must stop at the wrap without touching the descriptors before the start. A kick with transmit disabled must leave memory and the output untouched.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  // descriptor flag bit positions
  localparam int F_READY   = 15;
  localparam int F_OFFLOAD = 14;
  localparam int F_WRAP    = 13;
  localparam int F_INT     = 12;
  localparam int F_LAST    = 11;
  localparam int F_PAD     = 10;

  // flag bits that survive writeback: wrap, interrupt, last, pad, crc, bit 0
  localparam logic [15:0] FLAG_KEEP = 16'h3E01;

  typedef struct packed {
    logic [15:0] flags;
    logic [15:0] len;
    logic [31:0] bptr;
  } desc_t;

  typedef enum logic [3:0] {
    S_IDLE, S_D0, S_D0W, S_D1, S_D1W, S_EVAL,
    S_BR, S_BW, S_WB, S_ADV, S_DONE
  } walk_st_e;

endpackage

// File: rtl/tdr_desc_codec.sv
module tdr_desc_codec
  import tdr_pkg::*;
(
  input  logic        le,
  input  logic [31:0] w0,
  input  logic [31:0] w1,
  output desc_t       dsc,
  input  logic [15:0] wb_flags,
  input  logic [15:0] wb_len,
  output logic [31:0] wb_word
);

  always_comb begin
    if (le) begin
      dsc.flags = w0[15:0];
      dsc.len   = w0[31:16];
      dsc.bptr  = w1;
      wb_word   = {wb_len, wb_flags};
    end else begin
      dsc.flags = {w0[7:0], w0[15:8]};
      dsc.len   = {w0[23:16], w0[31:24]};
      dsc.bptr  = {w1[7:0], w1[15:8], w1[23:16], w1[31:24]};
      wb_word   = {wb_len[7:0], wb_len[15:8], wb_flags[7:0], wb_flags[15:8]};
    end
  end

endmodule

// File: rtl/tdr_byte_stream.sv
module tdr_byte_stream #(
  parameter int MIN_FRAME  = 64,
  parameter int DROP_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_vld,
  input  logic [7:0] in_byte,
  input  logic       in_eof,
  input  logic       drop_en,
  input  logic       pad_en,
  output logic       busy,
  output logic       tx_vld,
  output logic [7:0] tx_byte,
  output logic       tx_last
);

  localparam int CW = $clog2(MIN_FRAME + 1);
  localparam logic [CW-1:0] MINV  = CW'(MIN_FRAME);
  localparam logic [CW-1:0] DROPV = CW'(DROP_BYTES);

  logic [CW-1:0] cnt;      // frame byte count, saturating at MIN_FRAME
  logic          padding;
  logic [CW-1:0] cnt_inc;
  logic          keep;
  logic          pad_more;

  always_comb begin
    cnt_inc  = (cnt == MINV) ? cnt : cnt + CW'(1);
    keep     = !(drop_en && (cnt < DROPV));
    pad_more = pad_en && (cnt_inc < MINV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      padding <= 1'b0;
      tx_vld  <= 1'b0;
      tx_byte <= 8'h00;
      tx_last <= 1'b0;
    end else begin
      tx_vld  <= 1'b0;
      tx_last <= 1'b0;
      if (padding) begin
        tx_vld  <= keep;
        tx_byte <= 8'h00;
        tx_last <= keep && (cnt_inc == MINV);
        if (cnt_inc == MINV) begin
          padding <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt_inc;
        end
      end else if (in_vld) begin
        tx_vld  <= keep;
        tx_byte <= in_byte;
        tx_last <= keep && in_eof && !pad_more;
        if (in_eof) begin
          padding <= pad_more;
          cnt     <= pad_more ? cnt_inc : '0;
        end else begin
          cnt <= cnt_inc;
        end
      end
    end
  end

  assign busy = padding;

  AST_NO_PUSH_WHILE_PAD: assert property (@(posedge clk) disable iff (rst)
    padding |-> !in_vld); // R7
  AST_PAD_BYTES_ZERO: assert property (@(posedge clk) disable iff (rst)
    padding |=> (!tx_vld || tx_byte == 8'h00)); // R7

endmodule

// File: rtl/tdr_walker.sv
module tdr_walker
  import tdr_pkg::*;
#(
  parameter int ADDR_EXT_W = 4,
  parameter int RING_W     = 3,
  parameter int MIN_FRAME  = 64,
  parameter int DROP_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   kick,
  input  logic                   tx_enable,
  input  logic                   pad_enable,
  input  logic                   little_endian,
  input  logic [RING_W-1:0]      ring_id,
  input  logic [31:0]            ring_base,
  input  logic [31:0]            ring_ptr,
  input  logic [ADDR_EXT_W-1:0]  addr_ext,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [31+ADDR_EXT_W:0] mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic [31:0]            mem_rdata,
  output logic                   tx_vld,
  output logic [7:0]             tx_byte,
  output logic                   tx_last,
  output logic                   evt_buf,
  output logic                   evt_frame,
  output logic                   walk_done,
  output logic [31:0]            ptr_out,
  output logic [31:0]            halt_mask
);

  localparam int STAT_W = 32;
  localparam int DESC_B = 8;

  walk_st_e              st;
  logic [31:0]           cur, base_q, nxt_q, bptr;
  logic [31:0]           w0_q;
  logic [15:0]           remain;
  logic                  le_q, padg_q, frame_open, f_drop, f_pad;
  logic [ADDR_EXT_W-1:0] ext_q;
  logic [RING_W-1:0]     ring_q;
  desc_t                 dsc_q, dsc_dec;
  logic [31:0]           wb_word;
  logic                  s_busy, s_vld, s_eof;
  logic [7:0]            s_byte;

  tdr_desc_codec u_codec (
    .le       (le_q),
    .w0       (w0_q),
    .w1       (mem_rdata),
    .dsc      (dsc_dec),
    .wb_flags (dsc_q.flags & FLAG_KEEP),
    .wb_len   (dsc_q.len),
    .wb_word  (wb_word)
  );

  assign s_vld  = (st == S_BW);
  assign s_byte = mem_rdata[{bptr[1:0], 3'b000} +: 8];
  assign s_eof  = dsc_q.flags[F_LAST] && (remain == 16'd1);

  tdr_byte_stream #(.MIN_FRAME(MIN_FRAME), .DROP_BYTES(DROP_BYTES)) u_stream (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (s_vld),
    .in_byte (s_byte),
    .in_eof  (s_eof),
    .drop_en (f_drop),
    .pad_en  (f_pad),
    .busy    (s_busy),
    .tx_vld  (tx_vld),
    .tx_byte (tx_byte),
    .tx_last (tx_last)
  );

  // memory request decode from registered state
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st)
      S_D0: begin mem_req = 1'b1; mem_addr = {ext_q, cur}; end
      S_D1: begin mem_req = 1'b1; mem_addr = {ext_q, cur + 32'd4}; end
      S_BR: begin mem_req = 1'b1; mem_addr = {ext_q, bptr[31:2], 2'b00}; end
      S_WB: if (!s_busy) begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {ext_q, cur};
        mem_wdata = wb_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cur        <= '0;
      base_q     <= '0;
      nxt_q      <= '0;
      bptr       <= '0;
      w0_q       <= '0;
      remain     <= '0;
      le_q       <= 1'b0;
      padg_q     <= 1'b0;
      frame_open <= 1'b0;
      f_drop     <= 1'b0;
      f_pad      <= 1'b0;
      ext_q      <= '0;
      ring_q     <= '0;
      dsc_q      <= '0;
      evt_buf    <= 1'b0;
      evt_frame  <= 1'b0;
      walk_done  <= 1'b0;
      ptr_out    <= '0;
      halt_mask  <= '0;
    end else begin
      evt_buf   <= 1'b0;
      evt_frame <= 1'b0;
      walk_done <= 1'b0;
      unique case (st)
        S_IDLE: if (kick && tx_enable) begin
          cur    <= {ring_ptr[31:3], 3'b000};
          base_q <= {ring_base[31:3], 3'b000};
          le_q   <= little_endian;
          padg_q <= pad_enable;
          ext_q  <= addr_ext;
          ring_q <= ring_id;
          st     <= S_D0;
        end
        S_D0:  st <= S_D0W;
        S_D0W: begin w0_q <= mem_rdata; st <= S_D1; end
        S_D1:  st <= S_D1W;
        S_D1W: begin dsc_q <= dsc_dec; st <= S_EVAL; end
        S_EVAL: begin
          nxt_q <= dsc_q.flags[F_WRAP] ? base_q : cur + 32'(DESC_B);
          if (dsc_q.flags[F_READY] && dsc_q.len != 16'd0) begin
            if (!frame_open) begin
              f_drop <= dsc_q.flags[F_OFFLOAD];
              f_pad  <= dsc_q.flags[F_PAD] || padg_q;
            end
            frame_open <= 1'b1;
            bptr       <= dsc_q.bptr;
            remain     <= dsc_q.len;
            st         <= S_BR;
          end else begin
            st <= S_ADV;
          end
        end
        S_BR: st <= S_BW;
        S_BW: begin
          bptr   <= bptr + 32'd1;
          remain <= remain - 16'd1;
          st     <= (remain == 16'd1) ? S_WB : S_BR;
        end
        S_WB: if (!s_busy) begin
          evt_frame <= dsc_q.flags[F_INT] && dsc_q.flags[F_LAST];
          evt_buf   <= dsc_q.flags[F_INT] && !dsc_q.flags[F_LAST];
          if (dsc_q.flags[F_LAST]) frame_open <= 1'b0;
          st <= S_ADV;
        end
        S_ADV: begin
          cur <= nxt_q;
          st  <= (nxt_q == base_q) ? S_DONE : S_D0;
        end
        S_DONE: begin
          walk_done <= 1'b1;
          ptr_out   <= base_q;
          halt_mask <= STAT_W'(1) << (STAT_W - 1 - int'(ring_q));
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(evt_buf && evt_frame)); // R9
  AST_WB_READY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (le_q ? !mem_wdata[15] : !mem_wdata[7])); // R10
  AST_HALT_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    walk_done |-> $onehot(halt_mask)); // R4
  AST_PTR_OUT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    walk_done |-> (ptr_out[2:0] == 3'b000)); // R2
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !mem_req); // R11
  AST_NO_BYTES_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !s_busy) |=> !s_vld); // R11

endmodule

// File: tb/tdr_walker_tb.sv
`timescale 1ns/1ps
module tdr_walker_tb;

  localparam logic [3:0] EXT  = 4'h3;
  localparam logic [2:0] RING = 3'd2;
  localparam logic [15:0] RDY = 16'h8000, OFL = 16'h4000, WRP = 16'h2000,
                          INTF = 16'h1000, LST = 16'h0800, PADF = 16'h0400,
                          JUNK = 16'h01FF, KEEP = 16'h3E01;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        kick = 1'b0, tx_enable = 1'b1, pad_enable = 1'b0, little_endian = 1'b1;
  logic [2:0]  ring_id = RING;
  logic [31:0] ring_base = '0, ring_ptr = '0;
  logic [3:0]  addr_ext = EXT;
  logic        mem_req, mem_we;
  logic [35:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        tx_vld, tx_last, evt_buf, evt_frame, walk_done;
  logic [7:0]  tx_byte;
  logic [31:0] ptr_out, halt_mask;

  tdr_walker u_dut (
    .clk(clk), .rst(rst), .kick(kick), .tx_enable(tx_enable),
    .pad_enable(pad_enable), .little_endian(little_endian), .ring_id(ring_id),
    .ring_base(ring_base), .ring_ptr(ring_ptr), .addr_ext(addr_ext),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_vld(tx_vld), .tx_byte(tx_byte), .tx_last(tx_last),
    .evt_buf(evt_buf), .evt_frame(evt_frame), .walk_done(walk_done),
    .ptr_out(ptr_out), .halt_mask(halt_mask)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  int acc_cnt = 0, wr_cnt = 0, ext_err = 0;
  int nbuf = 0, nframe = 0, ndone = 0, nbytes = 0;
  logic [31:0] last_ptr, last_halt;
  bit finished = 0;

  logic [7:0] mem [0:4095];
  logic [7:0] fr [$];
  logic [8:0] expq [$];

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_req) begin
      automatic int a = int'(mem_addr[11:0]);
      acc_cnt++;
      if (mem_addr[35:32] != EXT || mem_addr[1:0] != 2'b00) ext_err++;
      if (mem_we) begin
        wr_cnt++;
        mem[a] = mem_wdata[7:0];   mem[a+1] = mem_wdata[15:8];
        mem[a+2] = mem_wdata[23:16]; mem[a+3] = mem_wdata[31:24];
      end else begin
        mem_rdata <= {mem[a+3], mem[a+2], mem[a+1], mem[a]};
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard compare and event counting
  always @(negedge clk) begin
    if (!rst) begin
      if (tx_vld) begin
        nbytes++;
        checks++;
        if (expq.size() == 0) begin
          failures++;
          $display("FAIL R6 unexpected byte actual=%0h expected=none", tx_byte);
        end else begin
          automatic logic [8:0] e = expq.pop_front();
          if ({tx_last, tx_byte} !== e) begin
            failures++;
            $display("FAIL R6 stream byte actual=%0h expected=%0h", {tx_last, tx_byte}, e);
          end
        end
      end
      if (evt_buf) nbuf++;
      if (evt_frame) nframe++;
      if (walk_done) begin
        ndone++;
        last_ptr = ptr_out;
        last_halt = halt_mask;
      end
    end
  end

  task automatic put_desc(int a, logic [15:0] fl, logic [15:0] ln, logic [31:0] p, bit le);
    if (le) begin
      mem[a] = fl[7:0]; mem[a+1] = fl[15:8]; mem[a+2] = ln[7:0]; mem[a+3] = ln[15:8];
      mem[a+4] = p[7:0]; mem[a+5] = p[15:8]; mem[a+6] = p[23:16]; mem[a+7] = p[31:24];
    end else begin
      mem[a] = fl[15:8]; mem[a+1] = fl[7:0]; mem[a+2] = ln[15:8]; mem[a+3] = ln[7:0];
      mem[a+4] = p[31:24]; mem[a+5] = p[23:16]; mem[a+6] = p[15:8]; mem[a+7] = p[7:0];
    end
  endtask

  function automatic logic [15:0] rd16(int a, bit le);
    return le ? {mem[a+1], mem[a]} : {mem[a], mem[a+1]};
  endfunction

  task automatic fill(int a, int n, logic [7:0] seed);
    for (int i = 0; i < n; i++) mem[a+i] = seed + 8'(i * 3);
  endtask

  task automatic grab(int a, int n);
    for (int i = 0; i < n; i++) fr.push_back(mem[a+i]);
  endtask

  task automatic commit(bit drop, bit pad);
    if (pad) while (fr.size() < 64) fr.push_back(8'h00);
    if (drop) for (int i = 0; i < 8; i++) if (fr.size() > 0) void'(fr.pop_front());
    for (int i = 0; i < fr.size(); i++)
      expq.push_back({(i == fr.size() - 1), fr[i]});
    fr.delete();
  endtask

  task automatic walk();
    automatic int d0 = ndone;
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    for (int i = 0; i < 20000 && ndone == d0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int b0, f0, d0, w0, a0, n0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("reset tx_vld", tx_vld, 0);
    check("reset walk_done", walk_done, 0);
    check("R11 reset mem_req", mem_req, 0);

    // T1: little-endian single-descriptor frame, R1 R4 R6 R9 R10
    little_endian = 1; pad_enable = 0;
    ring_base = 32'h100; ring_ptr = 32'h100;
    put_desc(32'h100, RDY | WRP | LST | INTF | JUNK, 16'd70, 32'h401, 1);
    fill(32'h401, 70, 8'h10);
    grab(32'h401, 70); commit(0, 0);
    b0 = nbuf; f0 = nframe; d0 = ndone;
    walk();
    check("R6 T1 all bytes delivered", expq.size(), 0);
    check("R9 T1 frame events", nframe - f0, 1);
    check("R9 T1 buffer events", nbuf - b0, 0);
    check("R4 T1 done count", ndone - d0, 1);
    check("R4 T1 ptr_out", last_ptr, 32'h100);
    check("R4 T1 halt_mask", last_halt, 32'h2000_0000);
    check("R10 T1 flags writeback", rd16(32'h100, 1), (RDY | WRP | LST | INTF | JUNK) & KEEP);
    check("R1 R10 T1 length kept", rd16(32'h102, 1), 16'd70);

    // T2: big-endian multi-descriptor frame with skips, R1 R2 R3 R5 R7
    little_endian = 0;
    ring_base = 32'h205; ring_ptr = 32'h207;
    put_desc(32'h200, RDY | PADF | INTF, 16'd10, 32'h503, 0);
    put_desc(32'h208, RDY, 16'd0, 32'h600, 0);
    put_desc(32'h210, INTF | LST, 16'd7, 32'h620, 0);
    put_desc(32'h218, RDY | LST | INTF | WRP, 16'd5, 32'h581, 0);
    fill(32'h503, 10, 8'h40); fill(32'h581, 5, 8'h90);
    grab(32'h503, 10); grab(32'h581, 5); commit(0, 1);
    b0 = nbuf; f0 = nframe; w0 = wr_cnt;
    walk();
    check("R7 R6 T2 padded frame delivered", expq.size(), 0);
    check("R9 T2 buffer events", nbuf - b0, 1);
    check("R9 T2 frame events", nframe - f0, 1);
    check("R3 R5 T2 writeback count", wr_cnt - w0, 2);
    check("R5 T2 zero-length untouched", rd16(32'h208, 0), RDY);
    check("R3 T2 not-ready untouched", rd16(32'h210, 0), INTF | LST);
    check("R2 T2 ptr_out masked base", last_ptr, 32'h200);
    check("R10 T2 BE writeback", rd16(32'h200, 0), PADF | INTF);

    // T3: offload with global padding, R7 R8
    little_endian = 1; pad_enable = 1;
    ring_base = 32'h300; ring_ptr = 32'h300;
    put_desc(32'h300, RDY | OFL | LST | WRP, 16'd20, 32'h700, 1);
    fill(32'h700, 20, 8'h21);
    grab(32'h700, 20); commit(1, 1);
    n0 = nbytes; b0 = nbuf; f0 = nframe;
    walk();
    check("R8 T3 byte count", nbytes - n0, 56);
    check("R8 T3 expected bytes", expq.size(), 0);
    check("R9 T3 no events without interrupt", (nbuf - b0) + (nframe - f0), 0);
    check("R10 T3 offload bit cleared", rd16(32'h300, 1), WRP | LST);

    // T4: flags of a later descriptor ignored, R12
    pad_enable = 0;
    put_desc(32'h300, RDY, 16'd4, 32'h720, 1);
    put_desc(32'h308, RDY | OFL | PADF | LST | WRP, 16'd5, 32'h730, 1);
    fill(32'h720, 4, 8'h61); fill(32'h730, 5, 8'h71);
    grab(32'h720, 4); grab(32'h730, 5); commit(0, 0);
    n0 = nbytes;
    walk();
    check("R12 T4 byte count", nbytes - n0, 9);
    check("R12 T4 expected bytes", expq.size(), 0);

    // T5: transmit disabled, R11
    tx_enable = 0;
    put_desc(32'h300, RDY | LST | WRP, 16'd4, 32'h720, 1);
    a0 = acc_cnt; d0 = ndone; n0 = nbytes;
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    repeat (100) @(negedge clk);
    check("R11 T5 memory accesses", acc_cnt - a0, 0);
    check("R11 T5 done pulses", ndone - d0, 0);
    check("R11 T5 output bytes", nbytes - n0, 0);
    check("R11 T5 descriptor untouched", rd16(32'h300, 1), RDY | LST | WRP);
    tx_enable = 1;

    // T6: walk starting mid-ring, R4
    ring_base = 32'h380; ring_ptr = 32'h390;
    put_desc(32'h380, RDY | LST, 16'd3, 32'h740, 1);
    put_desc(32'h388, RDY | LST, 16'd3, 32'h740, 1);
    put_desc(32'h390, RDY | LST | WRP, 16'd4, 32'h741, 1);
    fill(32'h740, 8, 8'hA0);
    grab(32'h741, 4); commit(0, 0);
    n0 = nbytes;
    walk();
    check("R4 T6 byte count", nbytes - n0, 4);
    check("R4 T6 earlier descriptor untouched", rd16(32'h380, 1), RDY | LST);
    check("R4 T6 ptr_out", last_ptr, 32'h380);
    check("R2 address extension and alignment", ext_err, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule